// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block turns a single management command into a complete clause-22 style frame on a two-wire serial management bus. The bus has a clock line, `mdc`, and a shared data line. The data line is exposed as three signals: an output value, an output enable and an input. A command selects read or write and carries a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block accepts the command only when it is idle.

The block generates the clock from the system clock. Each high or low phase of `mdc` lasts `HALF_CYC` system cycles. Every bit the master drives takes three phases: the value is placed while the clock is low, the clock then goes high, and the clock goes low again. A read frame releases the line for one full clock pulse and then clocks in 16 bits. A write frame sends the turnaround bits and the data itself, then releases the line for one low phase. `done` pulses when a frame finishes, and for a read it comes with the captured data.

Top module: `mdio_frame_master`

## Requirements
- R1: Out of reset, `busy`, `done`, `mdc` and `mdio_oe` are all 0. While the block is idle, `mdc` and `mdio_oe` stay 0.
- R2: Every frame begins with 32 driven one bits.
- R3: The preamble is followed by the start bits 0 then 1, and then by the opcode: 1,0 for a read and 0,1 for a write.
- R4: After the opcode come the 5-bit PHY address and then the 5-bit register address. Each field is sent most significant bit first.
- R5: For each driven bit, `mdio_out` changes only while `mdc` is low. It is held steady while `mdc` is high. Each high phase lasts `HALF_CYC` system cycles.
- R6: In a write frame the master drives the turnaround as 1 then 0, followed by the 16 write data bits, MSB first. A write frame therefore has 64 driven bits; a read frame has 46.
- R7: After the last write bit, `mdio_oe` goes low for exactly one low phase of `HALF_CYC` cycles. No `mdc` edge occurs during that phase, and then the frame ends.
- R8: In a read frame, after the register address, `mdio_oe` stays low for one full `mdc` pulse. The master then samples 16 bits from `mdio_in` at the end of each `mdc` high phase, MSB first. There are 17 rising `mdc` edges in total with the line released.
- R9: `done` is a one-cycle pulse. For a read, it is high in the cycle right after the 16th bit is captured, and `rdata` is valid in that cycle. `busy` is low whenever `done` is high.
- R10: A command presented while `busy` is high is ignored. No extra frame follows, and the running frame is unchanged.
- R11: When the block is idle and `cmd_valid` is high, `busy` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | Data line output enable |
| mdio_out | output | 1 | Data line driven value |
| mdio_in | input | 1 | Data line sampled value |

## Verification
Writes are tried with alternating, all-zero and all-one data at different addresses. This separates the field order, MSB-first shifting and the fixed turnaround bits from any stuck or shifted bit. Reads use responder patterns 8001, 7FFE and C35A at both extreme addresses. These expose a sample taken one edge early or late, and a bit order that is reversed. A second command issued mid-frame shows whether the block wrongly accepts while busy. Counting clock edges with the line released shows that a write adds no edge and a read adds exactly one release pulse.

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int HALF_CYC = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_read,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdc,
  output logic        mdio_oe,
  output logic        mdio_out,
  input  logic        mdio_in
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(HALF_CYC - 1);
  localparam int FRAME_W = 64;
  localparam logic [6:0] RD_BITS = 7'd46;
  localparam logic [6:0] WR_BITS = 7'd64;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_REL, S_RX, S_WREL} st_t;

  st_t                 st;
  logic [FRAME_W-1:0]  sh;
  logic [6:0]          nleft;
  logic [1:0]          ph;
  logic [CW-1:0]       cnt;
  logic                rd;
  logic [15:0]         rsh;
  logic                tick;
  logic                accept;

  assign tick     = (cnt == '0);
  assign accept   = (st == S_IDLE) && cmd_valid;
  assign busy     = (st != S_IDLE);
  assign mdio_oe  = (st == S_TX);
  assign mdio_out = (st == S_TX) ? sh[FRAME_W-1] : 1'b0;
  assign mdc      = (st == S_TX || st == S_REL) ? (ph == 2'd1) :
                    (st == S_RX) ? (ph == 2'd0) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sh    <= '0;
      nleft <= '0;
      ph    <= '0;
      cnt   <= '0;
      rd    <= 1'b0;
      rsh   <= '0;
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) cnt <= tick ? CNT_LOAD : cnt - 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          st  <= S_TX;
          ph  <= 2'd0;
          cnt <= CNT_LOAD;
          rd  <= cmd_read;
          if (cmd_read) begin
            sh    <= {32'hFFFF_FFFF, 2'b01, 2'b10, cmd_phy, cmd_reg, 18'd0};
            nleft <= RD_BITS;
          end else begin
            sh    <= {32'hFFFF_FFFF, 2'b01, 2'b01, cmd_phy, cmd_reg, 2'b10, cmd_wdata};
            nleft <= WR_BITS;
          end
        end
        S_TX: if (tick) begin
          if (ph == 2'd2) begin
            ph <= 2'd0;
            sh <= sh << 1;
            if (nleft == 7'd1) st <= rd ? S_REL : S_WREL;
            else nleft <= nleft - 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_REL: if (tick) begin
          if (ph == 2'd2) begin
            st    <= S_RX;
            ph    <= 2'd0;
            nleft <= 7'd16;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_RX: if (tick) begin
          if (ph == 2'd0) begin
            rsh <= {rsh[14:0], mdio_in};
            if (nleft == 7'd1) begin
              rdata <= {rsh[14:0], mdio_in};
              done  <= 1'b1;
              st    <= S_IDLE;
            end else begin
              ph <= 2'd1;
            end
          end else begin
            ph    <= 2'd0;
            nleft <= nleft - 1'b1;
          end
        end
        S_WREL: if (tick) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R1

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && mdc) |-> $stable(mdio_out)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy); // R11

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(done) && cmd_valid) |=> (busy || done)); // R10

endmodule

// File: tb/mdio_frame_master_bench.sv
module mdio_frame_master_bench;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [4:0] cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic busy, done, mdc, mdio_oe, mdio_out;
  logic [15:0] rdata;
  logic mdio_in = 1'b1;

  always #5 clk = ~clk;

  mdio_frame_master #(.HALF_CYC(HALF)) u_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rdata(rdata), .mdc(mdc),
    .mdio_oe(mdio_oe), .mdio_out(mdio_out), .mdio_in(mdio_in));

  int n_chk = 0, n_fail = 0;
  bit exp_bits[$];
  logic [16:0] exp_done[$];
  int tx_idx = 0, rel_rise = 0, rel_low = 0, hi_len = 0;
  logic [15:0] resp = '0;
  logic prev_mdc = 1'b0;
  logic rise_bit = 1'b0;
  logic hold_ok = 1'b1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string field_req(int i);
    if (i < 32) return "R2";
    if (i < 36) return "R3";
    if (i < 46) return "R4";
    return "R6";
  endfunction

  task automatic push_frame(input bit rdq, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    for (int i = 0; i < 32; i++) exp_bits.push_back(1'b1);
    exp_bits.push_back(1'b0); exp_bits.push_back(1'b1);
    exp_bits.push_back(rdq);  exp_bits.push_back(!rdq);
    for (int i = 4; i >= 0; i--) exp_bits.push_back(p[i]);
    for (int i = 4; i >= 0; i--) exp_bits.push_back(r[i]);
    if (!rdq) begin
      exp_bits.push_back(1'b1); exp_bits.push_back(1'b0);
      for (int i = 15; i >= 0; i--) exp_bits.push_back(d[i]);
    end
    exp_done.push_back({rdq, d});
  endtask

  // monitor and PHY responder, sampled mid-cycle
  always @(negedge clk) if (rst_n) begin
    if (mdc && !prev_mdc) begin
      if (mdio_oe) begin
        if (exp_bits.size() == 0) chk(1'b0, "R10", tx_idx, 0);
        else begin
          bit e;
          e = exp_bits.pop_front();
          chk(mdio_out == e, field_req(tx_idx), mdio_out, e);
        end
        tx_idx++;
        rise_bit = mdio_out;
        hold_ok = 1'b1;
      end else if (busy) rel_rise++;
      hi_len = 0;
    end
    if (mdc) begin
      hi_len++;
      if (mdio_oe && mdio_out != rise_bit) hold_ok = 1'b0;
    end
    if (!mdc && prev_mdc) begin
      chk(hi_len == HALF, "R5 high phase length", hi_len, HALF);
      if (mdio_oe) chk(hold_ok, "R5 data held", 0, 1);
      if (!mdio_oe && rel_rise >= 1 && rel_rise <= 16) mdio_in <= resp[16-rel_rise];
    end
    if (busy && !mdio_oe && !mdc) rel_low++;
    if (done) begin
      if (exp_done.size() == 0) chk(1'b0, "R10 extra done", 1, 0);
      else begin
        logic [16:0] ed;
        ed = exp_done.pop_front();
        chk(!busy, "R9 busy low at done", busy, 0);
        if (ed[16]) begin
          chk(rdata == ed[15:0], "R8 read data", rdata, ed[15:0]);
          chk(prev_mdc == 1'b1, "R9 done right after capture", prev_mdc, 1);
          chk(rel_rise == 17, "R8 released rising edges", rel_rise, 17);
        end else begin
          chk(rel_rise == 0, "R7 no edge after write", rel_rise, 0);
          chk(rel_low == HALF, "R7 release phase length", rel_low, HALF);
          chk(exp_bits.size() == 0, "R6 all bits sent", exp_bits.size(), 0);
        end
      end
    end
    prev_mdc = mdc;
  end

  task automatic run_cmd(input bit rdq, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input logic [15:0] rsp, input bit poke);
    resp = rsp;
    push_frame(rdq, p, r, rdq ? rsp : d);
    @(negedge clk);
    tx_idx = 0; rel_rise = 0; rel_low = 0; mdio_in = 1'b1;
    cmd_valid = 1'b1; cmd_read = rdq; cmd_phy = p; cmd_reg = r; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      cmd_valid = 1'b1; cmd_read = !rdq; cmd_phy = ~p; cmd_reg = ~r; cmd_wdata = ~d;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    repeat (30) begin
      @(negedge clk);
      chk(!busy && !mdc && !mdio_oe, "R10 R1 stays idle", {busy, mdc, mdio_oe}, 0);
    end
    chk(tx_idx == (rdq ? 46 : 64), "R6 driven bit count", tx_idx, rdq ? 46 : 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mdc && !mdio_oe, "R1 reset state", {busy, done, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mdc && !mdio_oe, "R1 idle after reset", {busy, mdc, mdio_oe}, 0);
    run_cmd(1'b0, 5'h13, 5'h04, 16'hA5C3, 16'h0, 1'b1);
    run_cmd(1'b1, 5'h01, 5'h02, 16'h0, 16'h8001, 1'b0);
    run_cmd(1'b1, 5'h1F, 5'h1F, 16'h0, 16'h7FFE, 1'b1);
    run_cmd(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0, 1'b0);
    run_cmd(1'b0, 5'h1F, 5'h10, 16'hFFFF, 16'h0, 1'b0);
    run_cmd(1'b1, 5'h00, 5'h00, 16'h0, 16'hC35A, 1'b0);
    chk(exp_done.size() == 0, "R9 every frame completed", exp_done.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule